// File: doc/BRIEF.md
# Flash Status Register Masked Update Engine

This block is a command sequencer that sits above a byte-wide SPI master. It changes selected bits of a serial flash device's two 8-bit status registers without disturbing the others. A request carries a 16-bit bit-select mask, a 16-bit target value and a flag that chooses a persistent or a temporary update. The engine reads both registers and joins them into one 16-bit word, with the first register in bits 7:0. If the selected bits already hold the target, it reports success and sends nothing more. Otherwise it arms the device with the write-enable command that matches the flag. It then sends the merged word in a single write command and waits for the write to settle. Finally it reads both registers back to confirm that the change took effect.

The byte interface is a request/acknowledge pair. The engine presents one transmit byte and a flag marking the last byte of a chip-select frame. The SPI master returns the received byte with a one-cycle acknowledge. It releases chip select after acknowledging the byte that carries the last-byte flag. Each command is its own frame. Results come back as a one-cycle `done` pulse and a 2-bit result code. The code is 0 for success, 1 when the register refused the change (locked) and 2 when the device stayed busy past the timeout.

Top module: `sreg_rmw_engine`

## Requirements
- R1: An accepted request first sends a 2-byte frame with opcode 0x05, then a 2-byte frame with opcode 0x35. The byte received in the second position of each frame forms bits 7:0 and bits 15:8 of the current word.
- R2: When (value & mask) equals (current & mask), the engine pulses `done` with result 0. It sends no write-enable frame and no write frame.
- R3: Before a write, the engine sends a 1-byte frame. The byte is 0x06 when `nonvol` was 1 at start, and 0x50 otherwise.
- R4: The write is one 3-byte frame: 0x01, then bits 7:0, then bits 15:8 of (current & ~mask) | (value & mask).
- R5: After a persistent write, the engine repeats 2-byte 0x05 frames until bit 0 of the received byte is 0. If that bit is still 1 on a poll that ends at least CLK_HZ/1000*TIMEOUT_MS cycles after the write frame ended, the engine finishes with result 2.
- R6: After a temporary write, the engine waits a fixed settle time of ceil(CLK_HZ*SETTLE_NS/1e9) cycles, at least 1. It sends no polling frames.
- R7: After the write, the engine rereads both registers as in R1. It finishes with result 1 when the selected bits differ from the target, and with result 0 otherwise.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. The running operation keeps its original mask, value and flag, and no extra `done` follows.
- R9: After reset, `busy`, `done`, `result` and `spi_req` are all 0.
- R10: `done` lasts exactly one cycle. `result` holds its value until the next accepted start. Each byte request keeps `spi_req` high with a stable byte until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| mask | input | 16 | Bits to change |
| value | input | 16 | Target bit values |
| nonvol | input | 1 | 1 for a persistent update, 0 for a temporary update |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 locked, 2 timeout |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Current byte ends the chip-select frame |
| spi_ack | input | 1 | Byte transferred |
| spi_rx | input | 8 | Byte received with the acknowledge |

## Verification
Several properties are checked on every cycle. Byte requests must stay stable until acknowledged, and `done` must stay a single pulse. The latched request must stay frozen against a start that arrives while busy. A timeout result may only follow a persistent update, and the byte interface must stay quiet while idle. Other behaviour can only be shown by the bench scenarios against its flash model. These scenarios cover the frame sequence and opcode choice, the merged word and its byte order, and the skip on an already-matching register. They also cover the lock detection through readback, the choice between polling and the fixed settle wait, and the timeout under a stuck busy bit.

// File: rtl/sreg_rmw_pkg.sv
package sreg_rmw_pkg;
  localparam logic [7:0] OP_RD_LO   = 8'h05;
  localparam logic [7:0] OP_RD_HI   = 8'h35;
  localparam logic [7:0] OP_WEN_NV  = 8'h06;
  localparam logic [7:0] OP_WEN_VOL = 8'h50;
  localparam logic [7:0] OP_WRITE   = 8'h01;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_LOCKED  = 2'd1,
    RES_TIMEOUT = 2'd2
  } result_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_DECIDE, ST_WREN, ST_WRSR,
    ST_POLL, ST_SETTLE, ST_VF_LO, ST_VF_HI, ST_CHECK
  } step_e;
endpackage

// File: rtl/sreg_frame_xfer.sv
module sreg_frame_xfer #(
  parameter int MAX_BYTES = 3,
  localparam int NB_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [NB_W-1:0]        nbytes,
  input  logic [MAX_BYTES*8-1:0] bytes_in,
  output logic                   fin,
  output logic [7:0]             rx_byte,
  output logic                   spi_req,
  output logic [7:0]             spi_tx,
  output logic                   spi_last,
  input  logic                   spi_ack,
  input  logic [7:0]             spi_rx
);
  logic [MAX_BYTES*8-1:0] shreg_q;
  logic [NB_W-1:0]        left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      left_q   <= '0;
      fin      <= 1'b0;
      rx_byte  <= '0;
      spi_req  <= 1'b0;
      spi_tx   <= '0;
      spi_last <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !spi_req) begin
        spi_req  <= 1'b1;
        spi_tx   <= bytes_in[7:0];
        shreg_q  <= bytes_in >> 8;
        left_q   <= nbytes - NB_W'(1);
        spi_last <= (nbytes == NB_W'(1));
      end else if (spi_req && spi_ack) begin
        rx_byte <= spi_rx;
        if (spi_last) begin
          spi_req  <= 1'b0;
          spi_last <= 1'b0;
          fin      <= 1'b1;
        end else begin
          spi_tx   <= shreg_q[7:0];
          shreg_q  <= shreg_q >> 8;
          left_q   <= left_q - NB_W'(1);
          spi_last <= (left_q == NB_W'(1));
        end
      end
    end
  end

  // R10: a pending byte stays offered unchanged until acknowledged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx) && $stable(spi_last)));

  // R10: a new frame is only launched when no frame is in flight
  assert_go_when_free_R10: assert property (@(posedge clk) disable iff (rst)
    go |-> !spi_req);
endmodule

// File: rtl/sreg_wait_timer.sv
module sreg_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (load) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      cnt_q   <= cnt_q + CW'(1);
      expired <= ((cnt_q + CW'(1)) >= limit);
    end
  end

  // R5: a fresh load always restarts the window
  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);
endmodule

// File: rtl/sreg_rmw_engine.sv
module sreg_rmw_engine
  import sreg_rmw_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int TIMEOUT_MS = 30,
  parameter int SETTLE_NS  = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] mask,
  input  logic [15:0] value,
  input  logic        nonvol,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic        spi_req,
  output logic [7:0]  spi_tx,
  output logic        spi_last,
  input  logic        spi_ack,
  input  logic [7:0]  spi_rx
);
  localparam int    TMO_CYC    = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam longint SETTLE_RAW = (longint'(CLK_HZ) * longint'(SETTLE_NS)
                                  + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int    SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int    LIM_MAX    = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int    TCW        = $clog2(LIM_MAX + 1);
  localparam int    FR_BYTES   = 3;
  localparam int    NB_W       = $clog2(FR_BYTES + 1);

  step_e       step_q;
  result_e     res_q;
  logic        done_q, issued_q, nv_q;
  logic [15:0] mask_q, val_q, cur_q;
  logic [15:0] merged;
  logic        frame_step, go, fin, tmr_load, tmr_expired;
  logic [7:0]  rx_byte;
  logic [7:0]  b0, b1, b2;
  logic [NB_W-1:0] nbytes;
  logic [TCW-1:0]  tmr_limit;

  assign merged = (cur_q & ~mask_q) | (val_q & mask_q);

  always_comb begin
    b0 = OP_RD_LO;
    b1 = 8'h00;
    b2 = 8'h00;
    nbytes = NB_W'(2);
    frame_step = 1'b1;
    case (step_q)
      ST_RD_LO, ST_VF_LO, ST_POLL: b0 = OP_RD_LO;
      ST_RD_HI, ST_VF_HI:          b0 = OP_RD_HI;
      ST_WREN: begin
        b0 = nv_q ? OP_WEN_NV : OP_WEN_VOL;
        nbytes = NB_W'(1);
      end
      ST_WRSR: begin
        b0 = OP_WRITE;
        b1 = merged[7:0];
        b2 = merged[15:8];
        nbytes = NB_W'(3);
      end
      default: frame_step = 1'b0;
    endcase
  end

  assign go        = frame_step && !issued_q;
  assign tmr_load  = (step_q == ST_WRSR) && fin;
  assign tmr_limit = nv_q ? TCW'(TMO_CYC) : TCW'(SETTLE_CYC);

  sreg_frame_xfer #(.MAX_BYTES(FR_BYTES)) u_xfer (
    .clk(clk), .rst(rst), .go(go), .nbytes(nbytes),
    .bytes_in({b2, b1, b0}), .fin(fin), .rx_byte(rx_byte),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last),
    .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  sreg_wait_timer #(.CW(TCW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .limit(tmr_limit),
    .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= ST_IDLE;
      res_q    <= RES_OK;
      done_q   <= 1'b0;
      issued_q <= 1'b0;
      nv_q     <= 1'b0;
      mask_q   <= '0;
      val_q    <= '0;
      cur_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) issued_q <= 1'b1;
      if (fin) issued_q <= 1'b0;
      case (step_q)
        ST_IDLE: if (start) begin
          mask_q <= mask;
          val_q  <= value;
          nv_q   <= nonvol;
          res_q  <= RES_OK;
          step_q <= ST_RD_LO;
        end
        ST_RD_LO: if (fin) begin
          cur_q[7:0] <= rx_byte;
          step_q     <= ST_RD_HI;
        end
        ST_RD_HI: if (fin) begin
          cur_q[15:8] <= rx_byte;
          step_q      <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (((cur_q ^ val_q) & mask_q) == 16'h0000) begin
            done_q <= 1'b1;
            res_q  <= RES_OK;
            step_q <= ST_IDLE;
          end else begin
            step_q <= ST_WREN;
          end
        end
        ST_WREN: if (fin) step_q <= ST_WRSR;
        ST_WRSR: if (fin) step_q <= nv_q ? ST_POLL : ST_SETTLE;
        ST_POLL: if (fin) begin
          if (!rx_byte[0]) begin
            step_q <= ST_VF_LO;
          end else if (tmr_expired) begin
            done_q <= 1'b1;
            res_q  <= RES_TIMEOUT;
            step_q <= ST_IDLE;
          end
        end
        ST_SETTLE: if (tmr_expired) step_q <= ST_VF_LO;
        ST_VF_LO: if (fin) begin
          cur_q[7:0] <= rx_byte;
          step_q     <= ST_VF_HI;
        end
        ST_VF_HI: if (fin) begin
          cur_q[15:8] <= rx_byte;
          step_q      <= ST_CHECK;
        end
        ST_CHECK: begin
          done_q <= 1'b1;
          res_q  <= (((cur_q ^ val_q) & mask_q) != 16'h0000) ? RES_LOCKED : RES_OK;
          step_q <= ST_IDLE;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (step_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the latched request is frozen while an operation runs
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mask_q) && $stable(val_q) && $stable(nv_q)));

  // R5: a timeout can only come from a persistent update
  assert_timeout_nv_only_R5: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd2) |-> nv_q);

  // R9: the byte interface is silent while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_req);

  // R10: no reserved result code is ever reported
  assert_result_legal_R10: assert property (@(posedge clk) disable iff (rst)
    result != 2'd3);
endmodule

// File: tb/sim_sreg_rmw_engine.sv
module sim_sreg_rmw_engine;
  localparam int NV = 7;
  localparam int TMO = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, nonvol = 1'b0;
  logic [15:0] mask = '0, value = '0;
  logic busy, done, spi_req, spi_last;
  logic [1:0] result;
  logic [7:0] spi_tx;
  logic spi_ack = 1'b0;
  logic [7:0] spi_rx = '0;

  always #2.5 clk = ~clk;

  sreg_rmw_engine #(.CLK_HZ(100_000), .TIMEOUT_MS(30), .SETTLE_NS(1000)) u0 (
    .clk(clk), .rst(rst), .start(start), .mask(mask), .value(value),
    .nonvol(nonvol), .busy(busy), .done(done), .result(result),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last),
    .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  localparam logic [15:0] T_INIT [NV] = '{16'h0000, 16'h0024, 16'h0024, 16'h4024, 16'h1234, 16'h00A0, 16'hFFFC};
  localparam logic [15:0] T_MASK [NV] = '{16'h007C, 16'h007C, 16'h4000, 16'h0180, 16'hFF00, 16'h0000, 16'h00FC};
  localparam logic [15:0] T_VAL  [NV] = '{16'h0024, 16'h0024, 16'h4000, 16'h0100, 16'hAB00, 16'hFFFF, 16'h0000};
  localparam logic        T_NV   [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        T_LOCK [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [1:0]  T_ERR  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0};
  localparam int          T_NWR  [NV] = '{1, 0, 1, 1, 1, 0, 1};
  localparam logic [7:0]  T_WEN  [NV] = '{8'h06, 8'h00, 8'h50, 8'h06, 8'h50, 8'h00, 8'h06};
  localparam int          T_RD05 [NV] = '{6, 1, 2, 6, 2, 1, 6};
  localparam logic [15:0] T_FIN  [NV] = '{16'h0024, 16'h0024, 16'h4024, 16'h4124, 16'h1234, 16'h00A0, 16'hFF00};

  int n_tests = 0, n_fail = 0;
  int cyc = 0, n_done = 0;

  // flash model state
  logic [15:0] dev_sr = '0;
  logic dev_lock = 1'b0, dev_stuck = 1'b0, wel = 1'b0;
  int busy_left = 0, byte_idx = 0;
  logic [7:0] cur_op = '0, wr_lo = '0, wr_hi = '0;
  int n_rd05 = 0, n_wren = 0, n_wr = 0, n_frames = 0;
  int last_wren_len = 0, last_wr_len = 0;
  logic [7:0] last_wren_op = '0;
  logic [7:0] op_log [4];

  task automatic clear_log();
    n_rd05 = 0; n_wren = 0; n_wr = 0; n_frames = 0;
    last_wren_len = 0; last_wr_len = 0; last_wren_op = 8'h00;
    for (int i = 0; i < 4; i++) op_log[i] = 8'h00;
  endtask

  initial forever @(posedge clk) cyc++;
  initial forever begin
    @(negedge clk);
    if (done) n_done++;
  end

  initial begin : flash_model
    logic [7:0] resp;
    int len;
    forever begin
      @(negedge clk);
      if (spi_ack) begin
        spi_ack = 1'b0;
      end else if (spi_req) begin
        resp = 8'hFF;
        if (byte_idx == 0) cur_op = spi_tx;
        else if (cur_op == 8'h05 && byte_idx == 1) begin
          resp = dev_sr[7:0] | {7'd0, (dev_stuck || busy_left > 0)};
          if (busy_left > 0) busy_left--;
        end else if (cur_op == 8'h35 && byte_idx == 1) resp = dev_sr[15:8];
        else if (cur_op == 8'h01 && byte_idx == 1) wr_lo = spi_tx;
        else if (cur_op == 8'h01 && byte_idx == 2) wr_hi = spi_tx;
        spi_rx = resp;
        spi_ack = 1'b1;
        if (spi_last) begin
          len = byte_idx + 1;
          if (n_frames < 4) op_log[n_frames] = cur_op;
          n_frames++;
          if (cur_op == 8'h05) n_rd05++;
          if (cur_op == 8'h06 || cur_op == 8'h50) begin
            n_wren++; last_wren_op = cur_op; last_wren_len = len; wel = 1'b1;
          end
          if (cur_op == 8'h01) begin
            n_wr++; last_wr_len = len;
            if (wel && !dev_lock && len == 3) begin
              dev_sr = {wr_hi, wr_lo};
              if (last_wren_op == 8'h06) busy_left = 3;
            end
            wel = 1'b0;
          end
          byte_idx = 0;
        end else begin
          byte_idx++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] m, input logic [15:0] v, input logic nv);
    @(negedge clk);
    mask = m; value = v; nonvol = nv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int took);
    int t0;
    t0 = cyc;
    while (!done) @(negedge clk);
    took = cyc - t0;
    @(negedge clk);
    chk(!done, "R10 done width", {31'd0, done}, 0);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int took, d0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 2'd0 && !spi_req, "R9 reset outputs",
        {28'd0, busy, done, result}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !spi_req, "R9 after reset release", {30'd0, busy, spi_req}, 0);

    for (int i = 0; i < NV; i++) begin
      dev_sr = T_INIT[i]; dev_lock = T_LOCK[i]; busy_left = 0;
      clear_log();
      issue(T_MASK[i], T_VAL[i], T_NV[i]);
      wait_done(took);
      chk(result == T_ERR[i], $sformatf("R7 vec%0d result", i), result, T_ERR[i]);
      chk(op_log[0] == 8'h05 && op_log[1] == 8'h35, $sformatf("R1 vec%0d read order", i),
          {op_log[0], op_log[1]}, 16'h0535);
      chk(n_wr == T_NWR[i], $sformatf("R2 vec%0d write frames", i), n_wr, T_NWR[i]);
      if (T_NWR[i] == 0)
        chk(n_wren == 0, $sformatf("R2 vec%0d no write enable", i), n_wren, 0);
      else begin
        chk(last_wren_op == T_WEN[i] && last_wren_len == 1, $sformatf("R3 vec%0d wren", i),
            {last_wren_op, 8'(last_wren_len)}, {T_WEN[i], 8'd1});
        chk(last_wr_len == 3, $sformatf("R4 vec%0d write len", i), last_wr_len, 3);
      end
      chk(dev_sr == T_FIN[i], $sformatf("R4 vec%0d device word", i), dev_sr, T_FIN[i]);
      chk(n_rd05 == T_RD05[i], $sformatf("R6 vec%0d 0x05 frame count", i), n_rd05, T_RD05[i]);
    end
    dev_lock = 1'b0;

    // R8: second start while busy is ignored
    dev_sr = 16'h0000; clear_log();
    d0 = n_done;
    issue(16'h00FF, 16'h0010, 1'b0);
    repeat (4) @(negedge clk);
    mask = 16'hFF00; value = 16'h5500; nonvol = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(took);
    repeat (50) @(negedge clk);
    chk(dev_sr == 16'h0010, "R8 original request applied", dev_sr, 16'h0010);
    chk(n_done - d0 == 1, "R8 single done", n_done - d0, 1);
    chk(!busy && result == 2'd0, "R8 idle with success", {30'd0, result}, 0);

    // R5: stuck busy gives a timeout after the window
    dev_sr = 16'h0000; dev_stuck = 1'b1; clear_log();
    issue(16'h0004, 16'h0004, 1'b1);
    wait_done(took);
    chk(result == 2'd2, "R5 timeout result", result, 2);
    chk(took >= TMO && took < TMO + 100, "R5 timeout window", took, TMO);
    dev_stuck = 1'b0;
    repeat (20) @(negedge clk);
    chk(result == 2'd2, "R10 result held", result, 2);

    // R6: volatile update completes quickly without polling
    dev_sr = 16'h0000; clear_log();
    issue(16'h0002, 16'h0002, 1'b0);
    wait_done(took);
    chk(took < 60 && n_rd05 == 2, "R6 short settle", took, 60);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule